// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends 8-bit characters over a single asynchronous serial line. Two storage stages are placed in series: a one-character holding stage that the bus writes into, and a shift stage that drives the line. While one character is on the wire, the next one can wait in the holding stage. The line therefore carries back-to-back frames with no idle gap, provided software or a DMA engine keeps the holding stage filled.

Two status flags report progress. The free flag is set whenever the holding stage can take a character. The same signal is driven out as the transmit request to a DMA engine, and each request is answered by one write. The done flag is set only when nothing is held and the shift stage has completed its stop bit.

Timing on the line comes from an external baud enable. Each pulse of this enable ends the bit that is currently being driven. The block does not generate the baud rate itself.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset with the transmitter enabled, the free flag is 1, the done flag is 1 and the line is 1.
- R2: A write taken while both stages are empty starts the frame on the next cycle: the line shows the start bit (0), the free flag stays 1 and the done flag is 0.
- R3: A write taken while a character is being shifted is held, and the free flag is 0 from the next cycle.
- R4: When the stop bit of the current frame ends (a baud pulse with the stop bit on the line) and a character is held, that character's start bit appears on the next cycle and the free flag returns to 1.
- R5: The done flag is 1 exactly when nothing is held and no frame is in progress. It rises on the cycle after the baud pulse that ends the last stop bit.
- R6: A frame is sent in this order: a 0 start bit, then data bit 0 through data bit 7, then the parity bit if parity is on, then a 1 stop bit. Each bit stays on the line until the baud pulse that ends it.
- R7: The parity select encoding is: 2'b00 no parity, 2'b01 even, 2'b10 odd, 2'b11 no parity. Even parity makes the count of ones in the data and parity bits even; odd parity makes it odd. The select is sampled when a character enters the shift stage.
- R8: The DMA request equals the free flag in every cycle.
- R9: A write offered while the free flag is 0 is ignored. The held character is kept and is the one sent next.
- R10: While the transmitter is disabled, both stages are cleared. From the next cycle the done flag is 1, the free flag is 0, and the line is 1. Re-enabling the transmitter sends nothing old.
- R11: The line is 1 whenever the transmitter is disabled or no frame is in progress.
- R12: A write taken in the same cycle as the stop-bit-ending baud pulse, with nothing held, enters the shift stage directly. Its start bit appears on the next cycle and the free flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable; low clears both stages |
| par_sel | input | 2 | Parity select: 00 none, 01 even, 10 odd, 11 none |
| baud_en | input | 1 | One-cycle pulse that ends the current bit |
| wr_valid | input | 1 | Write strobe for a character |
| wr_data | input | DATA_W | Character to send |
| txd | output | 1 | Serial line, idles high |
| hold_free | output | 1 | Holding stage can accept a character |
| line_done | output | 1 | Nothing held and no frame in progress |
| dma_req | output | 1 | Transmit request to the DMA engine |

## Verification
Two events can fall in the same cycle: completing a stop bit, and a write arriving. This happens when the holding stage is empty. The write must bypass into the shift stage, with no idle cycle and no stale entry left in the holding stage.

The bench provokes this directly by raising the write strobe together with the baud pulse that ends a stop bit. It then checks that the line shows a start bit on the very next cycle, with the free flag still high. A long random phase produces many more such collisions, as well as writes that arrive while the holding stage is full. A cycle-accurate model built from the requirements judges every one of them.

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [1:0]        par_sel,
  input  logic              baud_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              hold_free,
  output logic              line_done,
  output logic              dma_req
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic              hold_full;
  logic [DATA_W-1:0] hold_q;
  logic              busy;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;

  logic              accept, last, load, par_on, par_bit;
  logic [DATA_W-1:0] ld_data;
  logic [FRAME_W-1:0] frame_d;

  assign hold_free = tx_en & ~hold_full;
  assign dma_req   = hold_free;
  assign line_done = ~tx_en | (~hold_full & ~busy);
  assign txd       = (tx_en & busy) ? sh_q[0] : 1'b1;

  assign accept  = wr_valid & hold_free;
  assign last    = busy & baud_en & (left_q == CNT_W'(1));
  assign load    = (~busy | last) & (hold_full | accept);
  assign ld_data = hold_full ? hold_q : wr_data;
  assign par_on  = (par_sel == 2'b01) | (par_sel == 2'b10);
  assign par_bit = (^ld_data) ^ (par_sel == 2'b10);
  assign frame_d = par_on ? {1'b1, par_bit, ld_data, 1'b0}
                          : {2'b11, ld_data, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
      busy      <= 1'b0;
      sh_q      <= '1;
      left_q    <= '0;
    end else if (!tx_en) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
      busy      <= 1'b0;
      sh_q      <= '1;
      left_q    <= '0;
    end else begin
      if (load) begin
        sh_q   <= frame_d;
        left_q <= par_on ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
        busy   <= 1'b1;
      end else if (busy & baud_en) begin
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - CNT_W'(1);
        busy   <= ~last;
      end
      if (hold_full & load) begin
        hold_full <= 1'b0;
      end else if (accept & busy & ~last) begin
        hold_full <= 1'b1;
        hold_q    <= wr_data;
      end
    end
  end
endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              baud_en,
  input logic              wr_valid,
  input logic              txd,
  input logic              hold_free,
  input logic              line_done,
  input logic              hold_full,
  input logic              busy,
  input logic [DATA_W-1:0] hold_q
);
  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (txd && line_done));

  a_r3_free_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_free) |-> (!tx_en || $past(wr_valid)));

  a_r5_done_after_baud: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(line_done) && tx_en) |-> $past(baud_en));

  a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && wr_valid && line_done) |=> (!txd || !tx_en));

  a_r9_held_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && hold_full && !(busy && baud_en)) |=> (hold_full && $stable(hold_q)));
endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_en(baud_en),
  .wr_valid(wr_valid), .txd(txd), .hold_free(hold_free),
  .line_done(line_done), .hold_full(hold_full), .busy(busy), .hold_q(hold_q)
);

// File: tb/dbuf_uart_tx_tb_top.sv
`timescale 1ns/1ps
module dbuf_uart_tx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, baud_en = 1'b0, wr_valid = 1'b0;
  logic [1:0] par_sel = 2'b00;
  logic [7:0] wr_data = 8'h00;
  logic txd, hold_free, line_done, dma_req;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbuf_uart_tx #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .par_sel(par_sel), .baud_en(baud_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .txd(txd), .hold_free(hold_free),
    .line_done(line_done), .dma_req(dma_req)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [10:0] mk_frame(logic [7:0] d, logic [1:0] m);
    int ones = 0;
    logic p;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    p = (m == 2'b10) ? ((ones % 2) == 0) : ((ones % 2) == 1);
    if (m == 2'b01 || m == 2'b10) return {1'b1, p, d, 1'b0};
    return {2'b11, d, 1'b0};
  endfunction

  function automatic int frame_len(logic [1:0] m);
    return (m == 2'b01 || m == 2'b10) ? 11 : 10;
  endfunction

  // reference model of the requirements, one step per clock
  logic m_full = 1'b0, m_busy = 1'b0;
  logic [7:0] m_hold = 8'h00;
  logic [10:0] m_bits = '1;
  int m_left = 0;
  bit acc, fin;

  always @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      m_full <= 1'b0; m_busy <= 1'b0; m_left <= 0; m_bits <= '1;
    end else begin
      acc = wr_valid && !m_full;
      fin = m_busy && baud_en && (m_left == 1);
      if ((!m_busy || fin) && (m_full || acc)) begin
        m_bits <= mk_frame(m_full ? m_hold : wr_data, par_sel);
        m_left <= frame_len(par_sel);
        m_busy <= 1'b1;
        m_full <= 1'b0;
      end else begin
        if (m_busy && baud_en) begin
          m_bits <= {1'b1, m_bits[10:1]};
          m_left <= m_left - 1;
          m_busy <= !fin;
        end
        if (acc) begin
          m_full <= 1'b1;
          m_hold <= wr_data;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 line vs model", txd, (tx_en && m_busy) ? m_bits[0] : 1'b1);
      chk("R3 free vs model", hold_free, tx_en && !m_full);
      chk("R5 done vs model", line_done, !tx_en || (!m_full && !m_busy));
      chk("R8 request equals free", dma_req, hold_free);
    end
  end

  task automatic send_bits(logic [10:0] f, int n, string req);
    for (int i = 0; i < n; i++) begin
      chk(req, txd, f[i]);
      baud_en = 1'b1;
      @(negedge clk);
      baud_en = 1'b0;
    end
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [10:0] f;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1; tx_en = 1'b1;
    @(negedge clk);
    chk("R1 free after reset", hold_free, 1'b1);
    chk("R1 done after reset", line_done, 1'b1);
    chk("R1 line after reset", txd, 1'b1);

    wr_valid = 1'b1; wr_data = 8'hA5; par_sel = 2'b01;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R2 start bit", txd, 1'b0);
    chk("R2 free stays", hold_free, 1'b1);
    chk("R2 done low", line_done, 1'b0);

    wr_valid = 1'b1; wr_data = 8'h3C;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R3 free falls", hold_free, 1'b0);
    chk("R8 request falls", dma_req, 1'b0);

    wr_valid = 1'b1; wr_data = 8'hFF;
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R9 still full", hold_free, 1'b0);
    par_sel = 2'b00;
    send_bits(mk_frame(8'hA5, 2'b01), 11, "R6 even frame");
    chk("R4 free rises", hold_free, 1'b1);

    f = mk_frame(8'h3C, 2'b00);
    for (int i = 0; i < 10; i++) begin
      chk("R9 held char sent", txd, f[i]);
      baud_en = 1'b1;
      if (i == 9) begin wr_valid = 1'b1; wr_data = 8'h81; par_sel = 2'b10; end
      @(negedge clk);
      baud_en = 1'b0; wr_valid = 1'b0;
    end
    chk("R12 direct start", txd, 1'b0);
    chk("R12 free stays", hold_free, 1'b1);
    chk("R12 done low", line_done, 1'b0);

    f = mk_frame(8'h81, 2'b10);
    for (int i = 0; i < 11; i++) begin
      chk("R7 odd frame", txd, f[i]);
      if (i == 10) chk("R5 done low in stop", line_done, 1'b0);
      baud_en = 1'b1;
      @(negedge clk);
      baud_en = 1'b0;
    end
    chk("R5 done after stop", line_done, 1'b1);
    chk("R11 idle high", txd, 1'b1);

    wr_valid = 1'b1; wr_data = 8'h55;
    @(negedge clk);
    wr_data = 8'h0F;
    @(negedge clk);
    wr_valid = 1'b0; baud_en = 1'b1;
    @(negedge clk);
    baud_en = 1'b0; tx_en = 1'b0;
    chk("R11 line high when disabled", txd, 1'b1);
    @(negedge clk);
    chk("R10 free low", hold_free, 1'b0);
    chk("R10 done high", line_done, 1'b1);
    tx_en = 1'b1;
    @(negedge clk);
    chk("R10 nothing resumes", txd, 1'b1);
    chk("R10 free after enable", hold_free, 1'b1);
    chk("R10 done after enable", line_done, 1'b1);

    for (int n = 0; n < 20000; n++) begin
      baud_en  = ($urandom % 3) == 0;
      wr_valid = ($urandom % 6) == 0;
      wr_data  = 8'($urandom);
      if (($urandom % 40) == 0) par_sel = 2'($urandom);
      tx_en    = ($urandom % 700) != 0;
      @(negedge clk);
    end
    baud_en = 1'b0; wr_valid = 1'b0;
    finish_run();
  end
endmodule